// File: doc/BRIEF.md
# Raster Line and Position Interrupt Generator

This block turns the beam position of a video timing counter into three interrupt pulses. It watches the current raster line, the dot position inside that line and the field parity. It holds two vertical compare lines and one position interrupt setting. Each vertical compare fires at the start of its line. The position interrupt fires at a chosen dot offset, either once per frame at a fixed line or at a running target that moves forward by a fixed number of lines after each firing.

In interlaced operation, line numbers in the registers count field lines. Field line n maps to raster line 2n in the even field and 2n+1 in the odd field. Software writes the two registers through a simple write strobe with a one-bit select. The raster counter and the interrupt controller that gathers the pulses sit outside this block.

The position interrupt runs as a state machine with four states. PS_IDLE means it is disarmed. PS_FRAME means it compares against a fixed line. PS_WRAP reduces the running target. PS_COUNT compares against the reduced running target. A register write in frame or reserved mode moves the machine to PS_FRAME. A write in a counting mode moves it to PS_WRAP, or to PS_IDLE when half the total line count is zero. PS_WRAP subtracts half the total once per cycle while the target is above half the total, then moves to PS_COUNT. In PS_COUNT, a firing adds the step to the target and returns to PS_WRAP. PS_FRAME and PS_IDLE stay where they are until the next write.

Top module: `rsi_raster_irq`

## Requirements
- R1: While reset is held, all three interrupt outputs are 0. After reset both compare lines are 0 and the position interrupt is in per-frame mode at line 0 and offset 0, so all three fire at raster line 0, dot 0.
- R2: A write with select 0 sets compare line 1 from data bits 25:16 and compare line 2 from data bits 9:0. Each vertical interrupt fires when its mapped line is the raster line and the dot position is 0.
- R3: Each interrupt is a pulse one clock wide. It appears on the clock edge that samples the matching position. If the matching position is held on the next cycle, the pulse does not repeat.
- R4: With interlace on, field line n fires at raster line 2n when the field input is 0 and at 2n+1 when it is 1. With interlace off, it fires at raster line n.
- R5: When a mapped target line is equal to or greater than the total line input, that interrupt never fires.
- R6: A new compare value takes effect on the cycle after the write, so the interrupt can still fire later in the current field.
- R7: A write with select 1 sets the line or count from bits 9:0, the mode from bits 13:12 and the offset H from bits 25:16. The position interrupt fires at dot 2*H, limited to the line length minus 1.
- R8: Mode 0 and mode 3 both fire once per frame, at the programmed line.
- R9: Mode 1 uses the count N. The target starts at (raster line at the write, shifted right by 1) plus N. After each firing the target grows by N. Whenever the target exceeds half the total lines, half the total is subtracted until it no longer does.
- R10: Mode 2 behaves as mode 1 with N = 1 and ignores bits 9:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one dot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0: vertical compares, 1: position interrupt |
| wr_data_i | input | 32 | Write data |
| line_i | input | LW+1 | Current raster line |
| dot_i | input | DW | Current dot within the line |
| field_i | input | 1 | Field parity, 1 = odd |
| ilace_i | input | 1 | Interlaced numbering enable |
| total_i | input | LW+1 | Total raster lines per frame |
| line_len_i | input | DW | Dots per line |
| irq_v1_o | output | 1 | Compare line 1 pulse |
| irq_v2_o | output | 1 | Compare line 2 pulse |
| irq_pos_o | output | 1 | Position interrupt pulse |

## Verification
The vertical compares are driven at their exact line at dot 0 and at positions that miss by one line, one dot or the wrong field parity. This separates line matching from dot gating and from the 2n/2n+1 mapping. The position interrupt is tried in per-frame mode, in the reserved mode and with an offset large enough to be clamped, to show that both modes fire at a fixed line and that the clamp works. The counting modes are started from a known raster line and then visited in sequence, including the step past half the total. This tells the start value, the step, the wrap and the ignored count field of mode 2 apart.

// File: rtl/rsi_pkg.sv
package rsi_pkg;
    typedef enum logic [1:0] {
        PM_FRAME = 2'd0,
        PM_COUNT = 2'd1,
        PM_LINE  = 2'd2,
        PM_RSVD  = 2'd3
    } pmode_t;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_FRAME,
        PS_WRAP,
        PS_COUNT
    } pstate_t;
endpackage

// File: rtl/rsi_hit.sv
module rsi_hit #(
    parameter int LW = 10,
    parameter int DW = 12
) (
    input  logic          arm_i,
    input  logic [LW:0]   n_i,
    input  logic [DW-1:0] dot_tgt_i,
    input  logic [LW:0]   line_i,
    input  logic [DW-1:0] dot_i,
    input  logic          field_i,
    input  logic          ilace_i,
    input  logic [LW:0]   total_i,
    output logic          match_o
);
    logic [LW+1:0] mapped;

    // field line n -> raster 2n / 2n+1 when interlaced
    assign mapped  = ilace_i ? {n_i, field_i} : {1'b0, n_i};
    assign match_o = arm_i
                  && (mapped < {1'b0, total_i})
                  && (mapped == {1'b0, line_i})
                  && (dot_i == dot_tgt_i);
endmodule

// File: rtl/rsi_pos_seq.sv
module rsi_pos_seq
    import rsi_pkg::*;
#(
    parameter int LW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  pmode_t        wr_mode_i,
    input  logic [LW-1:0] wr_line_i,
    input  logic [LW:0]   cur_line_i,
    input  logic [LW:0]   total_i,
    input  logic          fire_i,
    output logic [LW:0]   tgt_o,
    output logic          arm_o
);
    pstate_t       state, state_n;
    logic [LW:0]   tgt, tgt_n;
    logic [LW-1:0] step, step_n;
    logic [LW:0]   half;

    assign half = total_i >> 1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PS_FRAME;
            tgt   <= '0;
            step  <= '0;
        end else begin
            state <= state_n;
            tgt   <= tgt_n;
            step  <= step_n;
        end
    end

    always_comb begin
        state_n = state;
        tgt_n   = tgt;
        step_n  = step;
        if (wr_i) begin
            unique case (wr_mode_i)
                PM_FRAME, PM_RSVD: begin
                    state_n = PS_FRAME;
                    tgt_n   = {1'b0, wr_line_i};
                end
                PM_COUNT, PM_LINE: begin
                    step_n  = (wr_mode_i == PM_LINE) ? LW'(1) : wr_line_i;
                    tgt_n   = (cur_line_i >> 1) + (LW+1)'(step_n);
                    state_n = (half == '0) ? PS_IDLE : PS_WRAP;
                end
            endcase
        end else begin
            unique case (state)
                PS_WRAP: begin
                    if (half == '0)      state_n = PS_IDLE;
                    else if (tgt > half) tgt_n   = tgt - half;
                    else                 state_n = PS_COUNT;
                end
                PS_COUNT: begin
                    if (fire_i) begin
                        tgt_n   = tgt + (LW+1)'(step);
                        state_n = PS_WRAP;
                    end
                end
                PS_IDLE, PS_FRAME: ;
            endcase
        end
    end

    always_comb begin
        tgt_o = tgt;
        arm_o = (state == PS_FRAME) || (state == PS_COUNT);
    end
endmodule

// File: rtl/rsi_raster_irq.sv
module rsi_raster_irq
    import rsi_pkg::*;
#(
    parameter int LW = 10,
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic          wr_sel_i,
    input  logic [31:0]   wr_data_i,
    input  logic [LW:0]   line_i,
    input  logic [DW-1:0] dot_i,
    input  logic          field_i,
    input  logic          ilace_i,
    input  logic [LW:0]   total_i,
    input  logic [DW-1:0] line_len_i,
    output logic          irq_v1_o,
    output logic          irq_v2_o,
    output logic          irq_pos_o
);
    localparam int NIRQ = 3;

    logic [LW-1:0] vc1, vc2, hofs;
    logic [DW-1:0] dot2, pos_dot;
    logic [LW:0]   pos_tgt;
    logic          pos_arm, wr_pos;
    logic [NIRQ-1:0] match, match_q, irq_q;
    logic [LW:0]     n_arr   [NIRQ];
    logic [DW-1:0]   dt_arr  [NIRQ];
    logic            arm_arr [NIRQ];

    assign wr_pos = wr_en_i && wr_sel_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vc1  <= '0;
            vc2  <= '0;
            hofs <= '0;
        end else if (wr_en_i) begin
            if (!wr_sel_i) begin
                vc1 <= wr_data_i[16 +: LW];
                vc2 <= wr_data_i[0 +: LW];
            end else begin
                hofs <= wr_data_i[16 +: LW];
            end
        end
    end

    assign dot2    = DW'({hofs, 1'b0});
    assign pos_dot = (dot2 >= line_len_i) ? line_len_i - DW'(1) : dot2;

    rsi_pos_seq #(.LW(LW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr_pos),
        .wr_mode_i  (pmode_t'(wr_data_i[13:12])),
        .wr_line_i  (wr_data_i[0 +: LW]),
        .cur_line_i (line_i),
        .total_i    (total_i),
        .fire_i     (match[2] & ~match_q[2]),
        .tgt_o      (pos_tgt),
        .arm_o      (pos_arm)
    );

    assign n_arr[0]   = {1'b0, vc1};
    assign n_arr[1]   = {1'b0, vc2};
    assign n_arr[2]   = pos_tgt;
    assign dt_arr[0]  = '0;
    assign dt_arr[1]  = '0;
    assign dt_arr[2]  = pos_dot;
    assign arm_arr[0] = 1'b1;
    assign arm_arr[1] = 1'b1;
    assign arm_arr[2] = pos_arm;

    for (genvar k = 0; k < NIRQ; k++) begin : g_hit
        rsi_hit #(.LW(LW), .DW(DW)) u_hit (
            .arm_i     (arm_arr[k]),
            .n_i       (n_arr[k]),
            .dot_tgt_i (dt_arr[k]),
            .line_i    (line_i),
            .dot_i     (dot_i),
            .field_i   (field_i),
            .ilace_i   (ilace_i),
            .total_i   (total_i),
            .match_o   (match[k])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= '0;
            irq_q   <= '0;
        end else begin
            match_q <= match;
            irq_q   <= match & ~match_q;
        end
    end

    assign irq_v1_o  = irq_q[0];
    assign irq_v2_o  = irq_q[1];
    assign irq_pos_o = irq_q[2];
endmodule

// File: rtl/rsi_raster_irq_chk.sv
module rsi_raster_irq_chk #(
    parameter int LW = 10,
    parameter int DW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic [LW:0]   line_i,
    input logic [DW-1:0] dot_i,
    input logic [LW:0]   total_i,
    input logic [DW-1:0] line_len_i,
    input logic          irq_v1_o,
    input logic          irq_v2_o,
    input logic          irq_pos_o
);
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !(irq_v1_o || irq_v2_o || irq_pos_o));

    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_v1_o || irq_v2_o || irq_pos_o) |=>
        !((irq_v1_o && $past(irq_v1_o)) || (irq_v2_o && $past(irq_v2_o))
          || (irq_pos_o && $past(irq_pos_o))));

    p_vert_dot_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_v1_o || irq_v2_o) |-> ($past(dot_i) == '0));

    p_line_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_v1_o || irq_v2_o || irq_pos_o) |-> ($past(line_i) < $past(total_i)));

    p_pos_dot_clamped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pos_o |-> ($past(dot_i) < $past(line_len_i)));
endmodule

bind rsi_raster_irq rsi_raster_irq_chk #(.LW(LW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_i     (line_i),
    .dot_i      (dot_i),
    .total_i    (total_i),
    .line_len_i (line_len_i),
    .irq_v1_o   (irq_v1_o),
    .irq_v2_o   (irq_v2_o),
    .irq_pos_o  (irq_pos_o)
);

// File: tb/tb_rsi_raster_irq.sv
module tb_rsi_raster_irq;
    localparam int LW = 10;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, wr_sel = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [LW:0]   line = '0;
    logic [DW-1:0] dot = '0;
    logic          field = 1'b0, ilace = 1'b0;
    logic [LW:0]   total = 11'd40;
    logic [DW-1:0] line_len = 12'd100;
    logic          irq_v1, irq_v2, irq_pos;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    rsi_raster_irq #(.LW(LW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
        .wr_data_i(wr_data), .line_i(line), .dot_i(dot), .field_i(field),
        .ilace_i(ilace), .total_i(total), .line_len_i(line_len),
        .irq_v1_o(irq_v1), .irq_v2_o(irq_v2), .irq_pos_o(irq_pos)
    );

    task automatic chk(string req, string what, logic got, logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic wr(logic sel, logic [31:0] d, logic [LW:0] at_line);
        line = at_line; dot = 12'd1; wr_sel = sel; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // present a position for one cycle, check the three pulses, then idle
    task automatic visit(string req, int ln, int dt, logic fl,
                         logic e1, logic e2, logic ep);
        line = LW'(ln); dot = DW'(dt); field = fl;
        @(negedge clk);
        chk(req, $sformatf("v1 @%0d/%0d/%0b", ln, dt, fl), irq_v1, e1);
        chk(req, $sformatf("v2 @%0d/%0d/%0b", ln, dt, fl), irq_v2, e2);
        chk(req, $sformatf("pos @%0d/%0d/%0b", ln, dt, fl), irq_pos, ep);
        dot = 12'd1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1", "v1 in reset", irq_v1, 1'b0);
        chk("R1", "pos in reset", irq_pos, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        // line 0 dot 0 presented: all reset targets fire
        chk("R1", "v1 at 0/0", irq_v1, 1'b1);
        chk("R1", "v2 at 0/0", irq_v2, 1'b1);
        chk("R1", "pos at 0/0", irq_pos, 1'b1);
        dot = 12'd1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_vert;
        wr(1'b0, (32'd12 << 16) | 32'd7, 11'd20);
        visit("R2", 12, 0, 1'b0, 1'b1, 1'b0, 1'b0);
        visit("R2", 12, 1, 1'b0, 1'b0, 1'b0, 1'b0);
        visit("R2", 7, 0, 1'b0, 1'b0, 1'b1, 1'b0);
        // R3: hold a matching position for two cycles
        line = 11'd7; dot = 12'd0;
        @(negedge clk);
        chk("R3", "v2 first cycle", irq_v2, 1'b1);
        @(negedge clk);
        chk("R3", "v2 held cycle", irq_v2, 1'b0);
        dot = 12'd1;
        repeat (2) @(negedge clk);
        // R6: rewrite while mid-field
        wr(1'b0, (32'd30 << 16) | 32'd7, 11'd20);
        visit("R6", 30, 0, 1'b0, 1'b1, 1'b0, 1'b0);
        visit("R6", 12, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_ilace;
        ilace = 1'b1; total = 11'd525;
        wr(1'b0, (32'd5 << 16) | 32'd300, 11'd100);
        visit("R4", 11, 0, 1'b1, 1'b1, 1'b0, 1'b0);
        visit("R4", 10, 0, 1'b1, 1'b0, 1'b0, 1'b0);
        visit("R4", 10, 0, 1'b0, 1'b1, 1'b0, 1'b0);
        visit("R5", 600, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        visit("R5", 601, 0, 1'b1, 1'b0, 1'b0, 1'b0);
        ilace = 1'b0; total = 11'd40; field = 1'b0;
    endtask

    task automatic t_frame;
        wr(1'b1, (32'd5 << 16) | (32'd0 << 12) | 32'd9, 11'd20);
        visit("R7", 9, 10, 1'b0, 1'b0, 1'b0, 1'b1);
        visit("R7", 9, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        visit("R8", 8, 10, 1'b0, 1'b0, 1'b0, 1'b0);
        wr(1'b1, (32'd100 << 16) | 32'd9, 11'd20);
        visit("R7", 9, 99, 1'b0, 1'b0, 1'b0, 1'b1);
        wr(1'b1, (32'd5 << 16) | (32'd3 << 12) | 32'd14, 11'd20);
        visit("R8", 14, 10, 1'b0, 1'b0, 1'b0, 1'b1);
        visit("R8", 9, 10, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_count;
        // half = 20; start 20>>1 + 3 = 13
        wr(1'b1, (32'd5 << 16) | (32'd1 << 12) | 32'd3, 11'd20);
        visit("R9", 13, 10, 1'b0, 1'b0, 1'b0, 1'b1);
        visit("R9", 13, 10, 1'b0, 1'b0, 1'b0, 1'b0);
        visit("R9", 16, 10, 1'b0, 1'b0, 1'b0, 1'b1);
        visit("R9", 19, 10, 1'b0, 1'b0, 1'b0, 1'b1);
        visit("R9", 22, 10, 1'b0, 1'b0, 1'b0, 1'b0);
        visit("R9", 2, 10, 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_every;
        // start 30>>1 + 1 = 16, count field 7 ignored
        wr(1'b1, (32'd5 << 16) | (32'd2 << 12) | 32'd7, 11'd30);
        visit("R10", 22, 10, 1'b0, 1'b0, 1'b0, 1'b0);
        visit("R10", 16, 10, 1'b0, 1'b0, 1'b0, 1'b1);
        visit("R10", 17, 10, 1'b0, 1'b0, 1'b0, 1'b1);
        visit("R10", 18, 10, 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_vert();
        t_ilace();
        t_frame();
        t_count();
        t_every();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule